// File: doc/BRIEF.md
# SD Host Normal Interrupt Status

This block keeps the normal interrupt status bits of an SD/MMC host controller. It sits between two clock domains. The card-side engines run on the SD bus clock and report transfer activity levels and one-cycle event strobes. Software reads and clears the status through a small register port on the host clock. The block turns activity-level falling edges and event strobes into sticky status bits. It merges the enabled bits into one interrupt request, and it resolves completion against timeout with fixed priority rules.

Events cross from the SD clock to the host clock through toggle synchronizers, one per status bit. A write-1-to-clear on the host side is not applied at once. The requested bits wait in a pending set and then in an in-flight set while a request toggle makes a round trip through the SD clock domain. The bits drop only when the acknowledge returns. Software can poll the interrupt request output to confirm that a clear has taken effect. A new event on a bit always beats a clear of that bit, so no event is lost.

Top module: `sdirq_status`

## Requirements
- R1: After reset the status bits, the signal-enable mask, the interrupt request and the four resolved outputs are all 0.
- R2: Transfer Complete (status bit 1) is set by a falling edge of the direction-selected level. When `xferIsWrite`=0 the level is `rdActive`; when `xferIsWrite`=1 it is `datActive`. A falling edge of the other level leaves the bit unchanged.
- R3: Block Gap Event (status bit 2) is set by a falling edge of `wrActive` while `stopGapReq`=1. A falling edge of `wrActive` while `stopGapReq`=0 leaves the bit unchanged.
- R4: Command Complete (status bit 0) is set by a `respEnd` strobe only when `respAutoCmd12`=0. A strobe with `respAutoCmd12`=1 leaves the bit unchanged.
- R5: A `cmdTimeout` strobe sets status bit 4. `cmdNoResp` equals bit 4. `cmdOk` is 1 only when bit 0 is 1 and bit 4 is 0, so the timeout takes priority.
- R6: A `dataTimeout` strobe sets status bit 5. `xferOk` equals bit 1. `xferTimedOut` is 1 only when bit 5 is 1 and bit 1 is 0, so completion takes priority.
- R7: Writing to address 0 clears each status bit whose data bit is 1. The bit stays visible on the cycle after the write and drops only after the SD-clock round trip. Data bits at 0 change nothing, and a status write leaves the mask unchanged.
- R8: A set event for a bit that arrives while a clear of that bit is pending, in flight or being applied leaves the bit at 1.
- R9: Card Interrupt (status bit 3) is set by a rising edge of `cardIrqLevel`. Once it is cleared it stays 0 while the level remains high, and it is set again only by the next rising edge.
- R10: `irqOut` is the OR over all bits of status ANDed with the mask. The mask is written and read at address 1. `hRdData` shows the status at address 0 and the mask at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hClk | input | 1 | Host register clock |
| sdClk | input | 1 | SD bus clock, slower than hClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| rdActive | input | 1 | Read transfer active level (sdClk) |
| wrActive | input | 1 | Write transfer active level (sdClk) |
| datActive | input | 1 | DAT line active level (sdClk) |
| xferIsWrite | input | 1 | Transfer direction, 1 = write |
| stopGapReq | input | 1 | Stop-at-block-gap request flag |
| respEnd | input | 1 | Response end-bit strobe (sdClk) |
| respAutoCmd12 | input | 1 | Qualifies respEnd as an automatic stop command |
| cmdTimeout | input | 1 | Command timeout strobe (sdClk) |
| dataTimeout | input | 1 | Data timeout strobe (sdClk) |
| cardIrqLevel | input | 1 | Card interrupt level (sdClk) |
| hAddr | input | 1 | Register select: 0 status, 1 mask |
| hWrEn | input | 1 | Register write strobe |
| hWrData | input | 6 | Write data |
| hRdData | output | 6 | Read data for the selected register |
| irqOut | output | 1 | Combined interrupt request |
| xferOk | output | 1 | Resolved: data transfer complete |
| xferTimedOut | output | 1 | Resolved: data timeout without completion |
| cmdOk | output | 1 | Resolved: response received correctly |
| cmdNoResp | output | 1 | Resolved: response not received |

## Verification
The bench builds the block with the default synchronizer depth of two stages. It runs the SD clock at one tenth of the host rate, with edges that never coincide, so every event and clear crosses in a fixed number of host cycles. This puts the delayed visibility of a clear within reach of an exact check on the cycle after the write. It also lets the bench overlap a clear and a new event on the same bit and compare the final value. A behavioural model in the bench follows the edges of each level and is compared on every settled host clock.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int NUM_BITS = 6;
  localparam int BIT_CMD  = 0;
  localparam int BIT_XFER = 1;
  localparam int BIT_GAP  = 2;
  localparam int BIT_CARD = 3;
  localparam int BIT_CTO  = 4;
  localparam int BIT_DTO  = 5;

  typedef logic [NUM_BITS-1:0] bitVec_t;

  typedef struct packed {
    bitVec_t setBits;
    bitVec_t clrBits;
  } strobes_t;
endpackage

// File: rtl/sdirq_sync.sv
module sdirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdirq_sdside.sv
module sdirq_sdside
  import sdirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    sdClk,
  input  logic    rstN,
  input  logic    rdActive,
  input  logic    wrActive,
  input  logic    datActive,
  input  logic    xferIsWrite,
  input  logic    stopGapReq,
  input  logic    respEnd,
  input  logic    respAutoCmd12,
  input  logic    cmdTimeout,
  input  logic    dataTimeout,
  input  logic    cardIrqLevel,
  input  logic    clrReqTog,
  output bitVec_t evTog,
  output logic    clrAckTog
);
  logic    rdPrev, wrPrev, datPrev, cardPrev;
  logic    rdFall, wrFall, datFall, cardRise;
  bitVec_t evPulse;

  always_comb begin
    rdFall   = rdPrev & ~rdActive;
    wrFall   = wrPrev & ~wrActive;
    datFall  = datPrev & ~datActive;
    cardRise = ~cardPrev & cardIrqLevel;
    evPulse            = '0;
    evPulse[BIT_CMD]   = respEnd & ~respAutoCmd12;
    evPulse[BIT_XFER]  = xferIsWrite ? datFall : rdFall;
    evPulse[BIT_GAP]   = wrFall & stopGapReq;
    evPulse[BIT_CARD]  = cardRise;
    evPulse[BIT_CTO]   = cmdTimeout;
    evPulse[BIT_DTO]   = dataTimeout;
  end

  always_ff @(posedge sdClk or negedge rstN) begin
    if (!rstN) begin
      rdPrev   <= 1'b0;
      wrPrev   <= 1'b0;
      datPrev  <= 1'b0;
      cardPrev <= 1'b0;
      evTog    <= '0;
    end else begin
      rdPrev   <= rdActive;
      wrPrev   <= wrActive;
      datPrev  <= datActive;
      cardPrev <= cardIrqLevel;
      evTog    <= evTog ^ evPulse;
    end
  end

  // the clear request toggle is mirrored back as the acknowledge
  sdirq_sync #(.STAGES(SYNC_STAGES)) uAckSync (
    .clk (sdClk),
    .rstN(rstN),
    .d   (clrReqTog),
    .q   (clrAckTog)
  );

  // R4: an automatic stop-command response never touches the command toggle
  assert_autocmd_quiet_R4: assert property (@(posedge sdClk) disable iff (!rstN)
    (respAutoCmd12 && !cmdTimeout) |=> $stable(evTog[BIT_CMD]));

  // R2: in write direction only a DAT-line fall moves the transfer toggle
  assert_write_dir_R2: assert property (@(posedge sdClk) disable iff (!rstN)
    (xferIsWrite && !(datPrev && !datActive)) |=> $stable(evTog[BIT_XFER]));
endmodule

// File: rtl/sdirq_ctrl.sv
module sdirq_ctrl
  import sdirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     hClk,
  input  logic     rstN,
  input  bitVec_t  evTog,
  input  logic     clrAckTog,
  input  bitVec_t  clrWrite,
  output strobes_t strobes,
  output logic     clrReqTog
);
  bitVec_t evSync, evSeen, setBits, clrBits;
  bitVec_t pendingQ, inflightQ;
  logic    busyQ, reqTogQ, ackSync, ackSeen, launch;

  generate
    for (genvar i = 0; i < NUM_BITS; i++) begin : gEvSync
      sdirq_sync #(.STAGES(SYNC_STAGES)) uSync (
        .clk (hClk),
        .rstN(rstN),
        .d   (evTog[i]),
        .q   (evSync[i])
      );
    end
  endgenerate

  sdirq_sync #(.STAGES(SYNC_STAGES)) uAckSync (
    .clk (hClk),
    .rstN(rstN),
    .d   (clrAckTog),
    .q   (ackSync)
  );

  assign setBits = evSync ^ evSeen;
  assign ackSeen = busyQ && (ackSync == reqTogQ);
  assign launch  = !busyQ && (pendingQ != '0);
  assign clrBits = ackSeen ? (inflightQ & ~setBits) : '0;

  always_ff @(posedge hClk or negedge rstN) begin
    if (!rstN) begin
      evSeen    <= '0;
      pendingQ  <= '0;
      inflightQ <= '0;
      busyQ     <= 1'b0;
      reqTogQ   <= 1'b0;
    end else begin
      evSeen   <= evSync;
      pendingQ <= ((launch ? '0 : pendingQ) | clrWrite) & ~setBits;
      if (ackSeen) begin
        busyQ <= 1'b0;
      end else if (launch) begin
        busyQ     <= 1'b1;
        reqTogQ   <= ~reqTogQ;
        inflightQ <= pendingQ & ~setBits;
      end else begin
        inflightQ <= inflightQ & ~setBits;
      end
    end
  end

  always_comb begin
    strobes.setBits = setBits;
    strobes.clrBits = clrBits;
  end

  assign clrReqTog = reqTogQ;

  // R7: the in-flight clear set holds while waiting for the acknowledge
  assert_inflight_hold_R7: assert property (@(posedge hClk) disable iff (!rstN)
    (busyQ && !ackSeen && setBits == '0) |=> $stable(inflightQ));
endmodule

// File: rtl/sdirq_dpath.sv
module sdirq_dpath
  import sdirq_pkg::*;
(
  input  logic     hClk,
  input  logic     rstN,
  input  strobes_t strobes,
  input  logic     maskWrEn,
  input  bitVec_t  maskWrData,
  input  logic     rdSel,
  output bitVec_t  rdData,
  output logic     irqOut,
  output logic     xferOk,
  output logic     xferTimedOut,
  output logic     cmdOk,
  output logic     cmdNoResp
);
  bitVec_t statusQ, maskQ;

  always_ff @(posedge hClk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= (statusQ & ~strobes.clrBits) | strobes.setBits;
      if (maskWrEn) maskQ <= maskWrData;
    end
  end

  assign rdData       = rdSel ? maskQ : statusQ;
  assign irqOut       = |(statusQ & maskQ);
  assign xferOk       = statusQ[BIT_XFER];
  assign xferTimedOut = statusQ[BIT_DTO] & ~statusQ[BIT_XFER];
  assign cmdOk        = statusQ[BIT_CMD] & ~statusQ[BIT_CTO];
  assign cmdNoResp    = statusQ[BIT_CTO];

  // R8: a set strobe always lands, even against a clear in the same cycle
  assert_set_wins_R8: assert property (@(posedge hClk) disable iff (!rstN)
    (strobes.setBits != '0) |=>
      ((statusQ & $past(strobes.setBits)) == $past(strobes.setBits)));

  // R7: a status bit only falls where the control issued a clear strobe
  assert_clear_gated_R7: assert property (@(posedge hClk) disable iff (!rstN)
    ((statusQ & ~strobes.clrBits) != '0) |=>
      ((statusQ & $past(statusQ & ~strobes.clrBits)) == $past(statusQ & ~strobes.clrBits)));
endmodule

// File: rtl/sdirq_status.sv
module sdirq_status
  import sdirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                hClk,
  input  logic                sdClk,
  input  logic                rstN,
  input  logic                rdActive,
  input  logic                wrActive,
  input  logic                datActive,
  input  logic                xferIsWrite,
  input  logic                stopGapReq,
  input  logic                respEnd,
  input  logic                respAutoCmd12,
  input  logic                cmdTimeout,
  input  logic                dataTimeout,
  input  logic                cardIrqLevel,
  input  logic                hAddr,
  input  logic                hWrEn,
  input  logic [NUM_BITS-1:0] hWrData,
  output logic [NUM_BITS-1:0] hRdData,
  output logic                irqOut,
  output logic                xferOk,
  output logic                xferTimedOut,
  output logic                cmdOk,
  output logic                cmdNoResp
);
  bitVec_t  evTog, clrWrite;
  logic     clrReqTog, clrAckTog, maskWrEn;
  strobes_t strobes;

  assign clrWrite = (hWrEn && !hAddr) ? hWrData : '0;
  assign maskWrEn = hWrEn && hAddr;

  sdirq_sdside #(.SYNC_STAGES(SYNC_STAGES)) uSd (
    .sdClk        (sdClk),
    .rstN         (rstN),
    .rdActive     (rdActive),
    .wrActive     (wrActive),
    .datActive    (datActive),
    .xferIsWrite  (xferIsWrite),
    .stopGapReq   (stopGapReq),
    .respEnd      (respEnd),
    .respAutoCmd12(respAutoCmd12),
    .cmdTimeout   (cmdTimeout),
    .dataTimeout  (dataTimeout),
    .cardIrqLevel (cardIrqLevel),
    .clrReqTog    (clrReqTog),
    .evTog        (evTog),
    .clrAckTog    (clrAckTog)
  );

  sdirq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .hClk     (hClk),
    .rstN     (rstN),
    .evTog    (evTog),
    .clrAckTog(clrAckTog),
    .clrWrite (clrWrite),
    .strobes  (strobes),
    .clrReqTog(clrReqTog)
  );

  sdirq_dpath uDp (
    .hClk        (hClk),
    .rstN        (rstN),
    .strobes     (strobes),
    .maskWrEn    (maskWrEn),
    .maskWrData  (hWrData),
    .rdSel       (hAddr),
    .rdData      (hRdData),
    .irqOut      (irqOut),
    .xferOk      (xferOk),
    .xferTimedOut(xferTimedOut),
    .cmdOk       (cmdOk),
    .cmdNoResp   (cmdNoResp)
  );
endmodule

// File: tb/sim_sdirq_status.sv
module sim_sdirq_status;
  logic hClk = 1'b0, sdClk = 1'b0, rstN = 1'b0;
  logic rdActive = 0, wrActive = 0, datActive = 0, xferIsWrite = 0, stopGapReq = 0;
  logic respEnd = 0, respAutoCmd12 = 0, cmdTimeout = 0, dataTimeout = 0, cardIrqLevel = 0;
  logic hAddr = 0, hWrEn = 0;
  logic [5:0] hWrData = '0;
  logic [5:0] hRdData;
  logic irqOut, xferOk, xferTimedOut, cmdOk, cmdNoResp;

  int nChk = 0, nBad = 0;
  logic cmpOn = 0, finished = 0;
  logic [5:0] mStat = '0, mMask = '0;
  logic mRd = 0, mWr = 0, mDat = 0, mCard = 0, mIsWr = 0, mGap = 0;
  logic [10:0] actVec, expVec;

  always #2 hClk = ~hClk;
  initial begin
    #1;
    forever #20 sdClk = ~sdClk;
  end

  sdirq_status u0 (
    .hClk(hClk), .sdClk(sdClk), .rstN(rstN),
    .rdActive(rdActive), .wrActive(wrActive), .datActive(datActive),
    .xferIsWrite(xferIsWrite), .stopGapReq(stopGapReq),
    .respEnd(respEnd), .respAutoCmd12(respAutoCmd12),
    .cmdTimeout(cmdTimeout), .dataTimeout(dataTimeout), .cardIrqLevel(cardIrqLevel),
    .hAddr(hAddr), .hWrEn(hWrEn), .hWrData(hWrData), .hRdData(hRdData),
    .irqOut(irqOut), .xferOk(xferOk), .xferTimedOut(xferTimedOut),
    .cmdOk(cmdOk), .cmdNoResp(cmdNoResp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge hClk) begin
    if (cmpOn && rstN && !finished) begin
      actVec = {hRdData, irqOut, xferOk, xferTimedOut, cmdOk, cmdNoResp};
      expVec = {(hAddr ? mMask : mStat), |(mStat & mMask), mStat[1],
                mStat[5] & ~mStat[1], mStat[0] & ~mStat[4], mStat[4]};
      chk("R5 R6 R10 per-cycle compare", {21'd0, actVec}, {21'd0, expVec});
    end
  end

  task automatic settle();
    repeat (2) @(posedge sdClk);
    repeat (6) @(posedge hClk);
    @(negedge hClk);
  endtask

  task automatic sdApply(input logic nRd, input logic nWr, input logic nDat, input logic nCard,
                         input logic nResp, input logic nAuto, input logic nCto, input logic nDto);
    logic [5:0] ev;
    cmpOn = 0;
    @(negedge sdClk);
    ev = '0;
    if (!mIsWr && mRd && !nRd) ev[1] = 1'b1;
    if (mIsWr && mDat && !nDat) ev[1] = 1'b1;
    if (mWr && !nWr && mGap) ev[2] = 1'b1;
    if (nResp && !nAuto) ev[0] = 1'b1;
    if (!mCard && nCard) ev[3] = 1'b1;
    if (nCto) ev[4] = 1'b1;
    if (nDto) ev[5] = 1'b1;
    rdActive = nRd; wrActive = nWr; datActive = nDat; cardIrqLevel = nCard;
    respEnd = nResp; respAutoCmd12 = nAuto; cmdTimeout = nCto; dataTimeout = nDto;
    mRd = nRd; mWr = nWr; mDat = nDat; mCard = nCard;
    @(negedge sdClk);
    respEnd = 0; respAutoCmd12 = 0; cmdTimeout = 0; dataTimeout = 0;
    settle();
    mStat = mStat | ev;
    cmpOn = 1;
  endtask

  task automatic setMode(input logic isWr, input logic gap);
    @(negedge sdClk);
    xferIsWrite = isWr; stopGapReq = gap;
    mIsWr = isWr; mGap = gap;
  endtask

  task automatic writeMask(input logic [5:0] v);
    cmpOn = 0;
    @(negedge hClk);
    hAddr = 1; hWrData = v; hWrEn = 1;
    @(negedge hClk);
    hWrEn = 0;
    chk("R10 mask readback", hRdData, v);
    hAddr = 0;
    mMask = v;
    cmpOn = 1;
  endtask

  task automatic readMask(input string tag, input logic [5:0] exp);
    cmpOn = 0;
    @(negedge hClk);
    hAddr = 1;
    #1;
    chk(tag, hRdData, exp);
    @(negedge hClk);
    hAddr = 0;
    cmpOn = 1;
  endtask

  task automatic clearBits(input logic [5:0] v);
    cmpOn = 0;
    @(negedge hClk);
    hAddr = 0; hWrData = v; hWrEn = 1;
    @(negedge hClk);
    hWrEn = 0;
    chk("R7 bit still visible one cycle after clear write", hRdData & v, mStat & v);
    repeat (4) @(posedge sdClk);
    repeat (8) @(posedge hClk);
    @(negedge hClk);
    mStat = mStat & ~v;
    cmpOn = 1;
  endtask

  initial begin
    repeat (50000) @(posedge hClk);
    if (!finished) begin
      finished = 1;
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [5:0] snap;
    repeat (3) @(posedge sdClk);
    @(negedge hClk);
    rstN = 1;
    @(negedge hClk);
    // R1 reset state
    chk("R1 status after reset", hRdData, 6'h00);
    chk("R1 irq after reset", irqOut, 1'b0);
    chk("R1 resolved outputs after reset", {xferOk, xferTimedOut, cmdOk, cmdNoResp}, 4'h0);
    readMask("R1 mask after reset", 6'h00);
    cmpOn = 1;

    writeMask(6'h3F);

    // R4 command complete and the auto stop-command exception
    sdApply(0, 0, 0, 0, 1, 1, 0, 0);
    chk("R4 auto stop response ignored", hRdData[0], 1'b0);
    sdApply(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 command complete set", hRdData[0], 1'b1);
    chk("R10 irq raised by enabled bit", irqOut, 1'b1);
    chk("R5 cmdOk with no timeout", cmdOk, 1'b1);

    // R5 timeout wins over command complete
    sdApply(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 timeout bit set", hRdData[4], 1'b1);
    chk("R5 resolved cmd pair", {cmdOk, cmdNoResp}, 2'b01);

    // R7 clear crosses domains, irq pollable
    clearBits(6'h11);
    chk("R7 cleared after round trip", hRdData, 6'h00);
    chk("R7 irq drops after clear", irqOut, 1'b0);

    // R2 read direction
    writeMask(6'h02);
    setMode(0, 0);
    sdApply(1, 0, 1, 0, 0, 0, 0, 0);
    sdApply(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 dat fall ignored in read", hRdData[1], 1'b0);
    chk("R10 irq low with nothing enabled set", irqOut, 1'b0);
    sdApply(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 read active fall sets complete", hRdData[1], 1'b1);
    chk("R10 masked irq", irqOut, 1'b1);
    chk("R6 xferOk", xferOk, 1'b1);
    clearBits(6'h02);

    // R2 / R3 write direction without gap request
    setMode(1, 0);
    sdApply(1, 1, 1, 0, 0, 0, 0, 0);
    sdApply(0, 1, 1, 0, 0, 0, 0, 0);
    chk("R2 read fall ignored in write", hRdData[1], 1'b0);
    sdApply(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 no gap event without request", hRdData[2], 1'b0);
    chk("R2 wr fall does not complete write", hRdData[1], 1'b0);
    sdApply(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 dat fall completes write", hRdData[1], 1'b1);
    clearBits(6'h02);

    // R3 stop at gap
    setMode(1, 1);
    sdApply(0, 1, 1, 0, 0, 0, 0, 0);
    sdApply(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 gap event set", hRdData[2], 1'b1);
    sdApply(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 complete after gap stop", hRdData[1], 1'b1);

    // R6 completion wins over data timeout
    sdApply(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R6 complete and timeout both set", {xferOk, xferTimedOut}, 2'b10);
    clearBits(6'h06);
    chk("R6 timeout alone", {xferOk, xferTimedOut}, 2'b01);
    clearBits(6'h20);
    setMode(0, 0);

    // R9 card interrupt
    writeMask(6'h3F);
    sdApply(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R9 card interrupt set on rise", hRdData[3], 1'b1);
    clearBits(6'h08);
    chk("R9 stays clear while level high", hRdData[3], 1'b0);
    sdApply(0, 0, 0, 1, 1, 0, 0, 0);
    chk("R9 no re-set without new rise", hRdData, 6'h01);
    sdApply(0, 0, 0, 0, 0, 0, 0, 0);
    sdApply(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R9 set again on next rise", hRdData[3], 1'b1);

    // R7 zero write changes nothing
    snap = hRdData;
    clearBits(6'h00);
    chk("R7 zero write leaves status", hRdData, snap);
    readMask("R7 status write leaves mask", 6'h3F);

    // R8 event during a clear in flight
    cmpOn = 0;
    @(negedge hClk);
    hAddr = 0; hWrData = 6'h01; hWrEn = 1;
    @(negedge hClk);
    hWrEn = 0;
    sdApply(0, 0, 0, 1, 1, 0, 0, 0);
    cmpOn = 0;
    repeat (4) @(posedge sdClk);
    repeat (8) @(posedge hClk);
    @(negedge hClk);
    chk("R8 event during clear survives", hRdData[0], 1'b1);
    cmpOn = 1;

    clearBits(6'h3F);
    chk("R7 all cleared", {hRdData, irqOut}, 7'h00);

    repeat (4) @(negedge hClk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule